// File: doc/BRIEF.md
# Queued Core-to-Bank Crossbar

This block switches single-word transfers from eight requesting cores to nine destinations: eight cache banks and one further non-cache unit. Each core offers one transfer at a time. The transfer carries a destination index and a data word, and it completes with a ready/valid handshake. An accepted transfer waits in a two-entry queue that belongs only to its source/destination pair. Because of this, a congested destination never stops a core from reaching other destinations.

Every destination has its own round-robin arbiter and its own short pipeline. A transfer moves through four stages in a fixed order:

1. Request: it is written into the pair queue.
2. Arbitration: a winner is recorded.
3. Selection: the winner's head word is switched across and popped.
4. Transmission: the word is held on the destination port until that port's ready is high.

Destinations run independently, so all nine can deliver in the same cycle.

Top module: `bank_xbar`

## Requirements
- R1: While reset is high and in the first cycle after it, every `dst_valid` bit is low. With no traffic, `src_ready` is high for every source whose `src_dst` holds a legal index (0 to 8).
- R2: With no contention and the destination ready, a transfer accepted in cycle k appears on `dst_valid`/`dst_data` of its destination in cycle k+4.
- R3: Each source/destination pair queues at most two transfers. If the destination's ready is held low from an idle state, one pair accepts exactly four transfers and then holds `src_ready` low. The four are one on the output, one in the selection register and two in the queue.
- R4: A source that is refused for one destination is still accepted for another destination whose pair queue has room.
- R5: Each destination grants sources in round-robin order. After source i is granted, the search starts at source i+1, wrapping from 7 to 0. The pointer starts at source 0 after reset.
- R6: Transfers from one source to one destination are delivered in issue order, with the word unchanged. `dst_src` names the originating source (0 to 7). Every accepted transfer is delivered exactly once.
- R7: While `dst_valid` is high and `dst_ready` is low, the next cycle shows the same valid word and the same source.
- R8: A stalled destination stalls only its own pipeline and arbitration. Other destinations keep delivering.
- R9: Transfers from different sources to different destinations that are accepted in the same cycle reach their outputs in the same cycle.
- R10: A `src_dst` value of 9 to 15 is refused: `src_ready` is low, and nothing is delivered on any destination.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_valid | input | 8 | Per-source request valid |
| src_dst | input | 32 | Per-source destination index, 4 bits per source (0-7 banks, 8 extra unit) |
| src_data | input | 256 | Per-source data word, 32 bits per source |
| src_ready | output | 8 | Per-source acceptance for the currently offered destination |
| dst_valid | output | 9 | Per-destination output valid |
| dst_ready | input | 9 | Per-destination output ready |
| dst_src | output | 27 | Originating source of the word on each destination, 3 bits each |
| dst_data | output | 288 | Data word on each destination, 32 bits each |

## Verification
Two functions can fall in the same cycle. One destination's output can be stalled with a full pair queue while the same source is accepted toward another destination, and that second destination must deliver while the first holds its word. The test provokes this directly: it holds one ready low, fills source 3's queue to that destination, and then redirects source 3 to another bank. It judges the result by the accepted count, by the second delivery arriving, and by the stalled word staying unchanged. A long random phase with random readiness on the outputs then mixes acceptances, stalls and concurrent deliveries on all nine destinations. Every word it sees is checked against per-pair sequence numbers carried in the data.

// File: rtl/bank_xbar_pkg.sv
`timescale 1ns/1ps
package bank_xbar_pkg;

    localparam int XB_SRCS   = 8;
    localparam int XB_DSTS   = 9;
    localparam int XB_WORD   = 32;
    localparam int XB_QDEPTH = 2;

    // index width, never below one bit
    function automatic int width_of(int n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction

    // modulo-n increment used by queue pointers and arbiter pointers
    function automatic int wrap_next(int idx, int n);
        return (idx + 1 >= n) ? 0 : idx + 1;
    endfunction

endpackage

// File: rtl/bank_xbar_pq.sv
`timescale 1ns/1ps
module bank_xbar_pq
    import bank_xbar_pkg::*;
#(
    parameter  int W     = 32,
    parameter  int DEPTH = 2,
    localparam int CW    = width_of(DEPTH + 1),
    localparam int PW    = width_of(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic          pop,
    output logic [W-1:0]  head,
    output logic [CW-1:0] cnt
);

    logic [W-1:0]  slot [DEPTH];
    logic [PW-1:0] wr_p;
    logic [PW-1:0] rd_p;

    function automatic logic [PW-1:0] bump(logic [PW-1:0] p);
        return PW'(wrap_next(int'(p), DEPTH));
    endfunction

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_p <= '0;
            rd_p <= '0;
            cnt  <= '0;
        end else begin
            if (push) wr_p <= bump(wr_p);
            if (pop)  rd_p <= bump(rd_p);
            cnt <= cnt + CW'(push) - CW'(pop);
        end
    end

    always_ff @(posedge clk) begin
        if (push) slot[wr_p] <= din;
    end

    assign head = slot[rd_p];

endmodule

// File: rtl/bank_xbar_rr.sv
`timescale 1ns/1ps
module bank_xbar_rr
    import bank_xbar_pkg::*;
#(
    parameter  int N  = 8,
    localparam int IW = width_of(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [N-1:0]  req,
    input  logic          adv,
    output logic          gnt_v,
    output logic [IW-1:0] gnt_idx
);

    logic [IW-1:0] ptr;

    // highest offset first so the lowest offset from ptr is the last to assign
    always_comb begin
        gnt_v   = 1'b0;
        gnt_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            int j;
            j = (int'(ptr) + i) % N;
            if (req[j]) begin
                gnt_v   = 1'b1;
                gnt_idx = IW'(j);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr <= '0;
        end else if (adv && gnt_v) begin
            ptr <= IW'(wrap_next(int'(gnt_idx), N));
        end
    end

endmodule

// File: rtl/bank_xbar_lane.sv
`timescale 1ns/1ps
module bank_xbar_lane
    import bank_xbar_pkg::*;
#(
    parameter  int NSRC = 8,
    parameter  int DW   = 32,
    parameter  int CW   = 2,
    localparam int SW   = width_of(NSRC)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NSRC*CW-1:0] q_cnt,
    input  logic [NSRC*DW-1:0] q_head,
    output logic [NSRC-1:0]    q_pop,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [SW-1:0]      out_src,
    output logic [DW-1:0]      out_data
);

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] src;
    } grant_t;

    typedef struct packed {
        logic          vld;
        logic [SW-1:0] src;
        logic [DW-1:0] data;
    } beat_t;

    grant_t          arb_r;
    beat_t           sel_r;
    beat_t           out_r;
    logic [NSRC-1:0] req;
    logic            gnt_v;
    logic [SW-1:0]   gnt_idx;
    logic            out_free;
    logic            sel_free;
    logic            arb_free;
    logic            sel_take;

    // a granted entry stays in its queue until selection pops it
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            req[s] = q_cnt[s*CW +: CW] > CW'(arb_r.vld && (arb_r.src == SW'(s)));
        end
    end

    assign out_free = !out_r.vld || out_ready;
    assign sel_free = !sel_r.vld || out_free;
    assign arb_free = !arb_r.vld || sel_free;
    assign sel_take = arb_r.vld && sel_free;

    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            q_pop[s] = sel_take && (arb_r.src == SW'(s));
        end
    end

    bank_xbar_rr #(.N(NSRC)) u_rr (
        .clk     (clk),
        .rst     (rst),
        .req     (req),
        .adv     (arb_free),
        .gnt_v   (gnt_v),
        .gnt_idx (gnt_idx)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            arb_r <= '0;
            sel_r <= '0;
            out_r <= '0;
        end else begin
            if (arb_free) begin
                arb_r.vld <= gnt_v;
                arb_r.src <= gnt_idx;
            end
            if (sel_free) begin
                sel_r.vld  <= arb_r.vld;
                sel_r.src  <= arb_r.src;
                sel_r.data <= q_head[arb_r.src*DW +: DW];
            end
            if (out_free) begin
                out_r <= sel_r;
            end
        end
    end

    assign out_valid = out_r.vld;
    assign out_src   = out_r.src;
    assign out_data  = out_r.data;

endmodule

// File: rtl/bank_xbar.sv
`timescale 1ns/1ps
module bank_xbar
    import bank_xbar_pkg::*;
#(
    parameter  int NSRC  = XB_SRCS,
    parameter  int NDST  = XB_DSTS,
    parameter  int DW    = XB_WORD,
    parameter  int DEPTH = XB_QDEPTH,
    localparam int SW    = width_of(NSRC),
    localparam int DSTW  = width_of(NDST),
    localparam int CW    = width_of(DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NSRC-1:0]      src_valid,
    input  logic [NSRC*DSTW-1:0] src_dst,
    input  logic [NSRC*DW-1:0]   src_data,
    output logic [NSRC-1:0]      src_ready,
    output logic [NDST-1:0]      dst_valid,
    input  logic [NDST-1:0]      dst_ready,
    output logic [NDST*SW-1:0]   dst_src,
    output logic [NDST*DW-1:0]   dst_data
);

    localparam int NPAIR = NSRC * NDST;

    logic [NPAIR-1:0]    pair_push;
    logic [NPAIR-1:0]    pair_pop;
    logic [NPAIR*CW-1:0] pair_cnt;
    logic [NPAIR*DW-1:0] pair_head;

    // acceptance: legal destination index and room in that pair's queue
    always_comb begin
        for (int s = 0; s < NSRC; s++) begin
            src_ready[s] = 1'b0;
            for (int d = 0; d < NDST; d++) begin
                if (src_dst[s*DSTW +: DSTW] == DSTW'(d) &&
                    pair_cnt[(s*NDST+d)*CW +: CW] < CW'(DEPTH)) begin
                    src_ready[s] = 1'b1;
                end
            end
        end
    end

    for (genvar s = 0; s < NSRC; s++) begin : g_src
        for (genvar d = 0; d < NDST; d++) begin : g_pair
            localparam int P = s * NDST + d;

            assign pair_push[P] = src_valid[s] && src_ready[s] &&
                                  (src_dst[s*DSTW +: DSTW] == DSTW'(d));

            bank_xbar_pq #(.W(DW), .DEPTH(DEPTH)) u_q (
                .clk  (clk),
                .rst  (rst),
                .push (pair_push[P]),
                .din  (src_data[s*DW +: DW]),
                .pop  (pair_pop[P]),
                .head (pair_head[P*DW +: DW]),
                .cnt  (pair_cnt[P*CW +: CW])
            );
        end
    end

    for (genvar d = 0; d < NDST; d++) begin : g_dst
        logic [NSRC*CW-1:0] lane_cnt;
        logic [NSRC*DW-1:0] lane_head;
        logic [NSRC-1:0]    lane_pop;

        for (genvar s = 0; s < NSRC; s++) begin : g_map
            assign lane_cnt[s*CW +: CW]        = pair_cnt[(s*NDST+d)*CW +: CW];
            assign lane_head[s*DW +: DW]       = pair_head[(s*NDST+d)*DW +: DW];
            assign pair_pop[s*NDST+d]          = lane_pop[s];
        end

        bank_xbar_lane #(.NSRC(NSRC), .DW(DW), .CW(CW)) u_lane (
            .clk       (clk),
            .rst       (rst),
            .q_cnt     (lane_cnt),
            .q_head    (lane_head),
            .q_pop     (lane_pop),
            .out_valid (dst_valid[d]),
            .out_ready (dst_ready[d]),
            .out_src   (dst_src[d*SW +: SW]),
            .out_data  (dst_data[d*DW +: DW])
        );
    end

endmodule

// File: rtl/bank_xbar_chk.sv
`timescale 1ns/1ps
module bank_xbar_chk
    import bank_xbar_pkg::*;
#(
    parameter  int NSRC  = 8,
    parameter  int NDST  = 9,
    parameter  int DW    = 32,
    parameter  int DEPTH = 2,
    localparam int SW    = width_of(NSRC),
    localparam int CW    = width_of(DEPTH + 1),
    localparam int NPAIR = NSRC * NDST
) (
    input logic                clk,
    input logic                rst,
    input logic [NDST-1:0]     dst_valid,
    input logic [NDST-1:0]     dst_ready,
    input logic [NDST*SW-1:0]  dst_src,
    input logic [NDST*DW-1:0]  dst_data,
    input logic [NPAIR-1:0]    pair_push,
    input logic [NPAIR-1:0]    pair_pop,
    input logic [NPAIR*CW-1:0] pair_cnt
);

    AST_RESET_IDLE: assert property (@(posedge clk) rst |=> (dst_valid == '0)); // R1

    for (genvar d = 0; d < NDST; d++) begin : g_d
        AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
            (dst_valid[d] && !dst_ready[d]) |=>
            (dst_valid[d] && $stable(dst_data[d*DW +: DW]) && $stable(dst_src[d*SW +: SW]))); // R7
    end

    for (genvar p = 0; p < NPAIR; p++) begin : g_p
        AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
            pair_push[p] |-> (pair_cnt[p*CW +: CW] < CW'(DEPTH))); // R3
        AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
            pair_cnt[p*CW +: CW] <= CW'(DEPTH)); // R3
        AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
            pair_pop[p] |-> (pair_cnt[p*CW +: CW] != '0)); // R6
    end

endmodule

bind bank_xbar bank_xbar_chk #(
    .NSRC(NSRC), .NDST(NDST), .DW(DW), .DEPTH(DEPTH)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dst_valid (dst_valid),
    .dst_ready (dst_ready),
    .dst_src   (dst_src),
    .dst_data  (dst_data),
    .pair_push (pair_push),
    .pair_pop  (pair_pop),
    .pair_cnt  (pair_cnt)
);

// File: tb/sim_bank_xbar.sv
`timescale 1ns/1ps
module sim_bank_xbar;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [7:0]   src_valid = '0;
    logic [31:0]  src_dst = '0;
    logic [255:0] src_data = '0;
    logic [7:0]   src_ready;
    logic [8:0]   dst_valid;
    logic [8:0]   dst_ready = '1;
    logic [26:0]  dst_src;
    logic [287:0] dst_data;

    int checks = 0;
    int fails = 0;
    bit done = 0;
    int issue_seq [8][9];
    int exp_seq [8][9];
    bit prev_stall [9];
    logic [31:0] prev_word [9];
    logic [2:0]  prev_src [9];
    bit acc_seen [8];
    bit rdy_seen [8];

    always #5 clk = ~clk;

    bank_xbar u0 (
        .clk(clk), .rst(rst), .src_valid(src_valid), .src_dst(src_dst),
        .src_data(src_data), .src_ready(src_ready), .dst_valid(dst_valid),
        .dst_ready(dst_ready), .dst_src(dst_src), .dst_data(dst_data)
    );

    task automatic chk(bit ok, string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // word layout: [31:28] source, [27:24] destination, [23:0] per-pair sequence
    task automatic offer(int s, int d);
        src_valid[s] = 1'b1;
        src_dst[s*4 +: 4] = 4'(d);
        src_data[s*32 +: 32] = {4'(s), 4'(d), 24'((d < 9) ? issue_seq[s][d] : 0)};
    endtask

    // sample late in the cycle, then return just after the next falling edge
    task automatic step();
        #2;
        for (int d = 0; d < 9; d++) begin
            if (prev_stall[d])
                chk(dst_valid[d] && dst_data[d*32 +: 32] == prev_word[d] &&
                    dst_src[d*3 +: 3] == prev_src[d], "R7 hold",
                    {dst_valid[d], dst_data[d*32 +: 32]}, {1'b1, prev_word[d]});
        end
        for (int s = 0; s < 8; s++) begin
            int d;
            d = int'(src_dst[s*4 +: 4]);
            rdy_seen[s] = src_ready[s];
            acc_seen[s] = src_valid[s] && src_ready[s];
            if (acc_seen[s] && d < 9) issue_seq[s][d]++;
        end
        for (int d = 0; d < 9; d++) begin
            if (dst_valid[d] && dst_ready[d]) begin
                int sr;
                logic [31:0] w;
                logic [31:0] e;
                sr = int'(dst_src[d*3 +: 3]);
                w  = dst_data[d*32 +: 32];
                e  = {4'(sr), 4'(d), 24'(exp_seq[sr][d])};
                chk(w == e, "R6 order/data", w, e);
                exp_seq[sr][d]++;
            end
            prev_stall[d] = dst_valid[d] && !dst_ready[d];
            prev_word[d]  = dst_data[d*32 +: 32];
            prev_src[d]   = dst_src[d*3 +: 3];
        end
        @(negedge clk);
        #1;
        src_valid = '0;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        for (int s = 0; s < 8; s++)
            for (int d = 0; d < 9; d++) begin
                issue_seq[s][d] = 0;
                exp_seq[s][d] = 0;
            end
        for (int d = 0; d < 9; d++) prev_stall[d] = 0;

        // R1: reset state
        repeat (3) @(negedge clk);
        #1;
        chk(dst_valid == '0, "R1 valid in reset", dst_valid, 0);
        rst = 1'b0;
        @(negedge clk);
        #1;
        chk(dst_valid == '0, "R1 valid after reset", dst_valid, 0);
        chk(src_ready == 8'hFF, "R1 ready after reset", src_ready, 8'hFF);

        // R2: uncontended latency
        begin
            int n;
            offer(0, 4);
            step();
            chk(acc_seen[0], "R2 accept", acc_seen[0], 1);
            n = 1;
            while (!dst_valid[4] && n < 10) begin
                step();
                n++;
            end
            chk(n == 4, "R2 latency", n, 4);
        end
        repeat (6) step();

        // R9: two destinations delivered in the same cycle
        offer(1, 2);
        offer(5, 7);
        step();
        repeat (3) step();
        chk(dst_valid[2] && dst_valid[7], "R9 same cycle", {dst_valid[2], dst_valid[7]}, 2'b11);
        repeat (6) step();

        // R5: round-robin order after source 5 was served first
        offer(5, 0);
        step();
        repeat (8) step();
        for (int s = 0; s < 8; s++) offer(s, 0);
        step();
        begin
            int k;
            k = 0;
            for (int c = 0; c < 16; c++) begin
                if (dst_valid[0] && k < 8) begin
                    chk(int'(dst_src[2:0]) == (6 + k) % 8, "R5 round robin",
                        dst_src[2:0], (6 + k) % 8);
                    k++;
                end
                step();
            end
            chk(k == 8, "R5 grant count", k, 8);
        end
        repeat (4) step();

        // R3: stalled output, one pair accepts exactly four
        dst_ready[2] = 1'b0;
        begin
            int got;
            got = 0;
            for (int c = 0; c < 8; c++) begin
                offer(3, 2);
                step();
                if (acc_seen[3]) got++;
            end
            chk(got == 4, "R3 accepted while stalled", got, 4);
            chk(!rdy_seen[3], "R3 refused when full", rdy_seen[3], 0);
        end
        // R4: same source, other destination, still accepted
        offer(3, 5);
        step();
        chk(acc_seen[3], "R4 other destination accepted", acc_seen[3], 1);
        // R8: destination 5 delivers while destination 2 is stalled
        begin
            bit got5;
            got5 = 0;
            for (int c = 0; c < 6; c++) begin
                if (dst_valid[5] && dst_src[17:15] == 3'd3) got5 = 1;
                step();
            end
            chk(got5 && dst_valid[2], "R8 independent lanes", {got5, dst_valid[2]}, 2'b11);
        end
        dst_ready[2] = 1'b1;
        repeat (10) step();

        // R10: illegal destination indices
        for (int bad = 9; bad < 16; bad += 3) begin
            bit any;
            any = 0;
            offer(0, bad);
            step();
            chk(!rdy_seen[0] && !acc_seen[0], "R10 refused", rdy_seen[0], 0);
            for (int c = 0; c < 6; c++) begin
                if (dst_valid != '0) any = 1;
                step();
            end
            chk(!any, "R10 nothing delivered", any, 0);
        end

        // random phase (R6, R7, R8)
        for (int c = 0; c < 3000; c++) begin
            for (int d = 0; d < 9; d++) dst_ready[d] = ($urandom % 4) != 0;
            for (int s = 0; s < 8; s++)
                if (($urandom % 10) < 6) offer(s, int'($urandom % 9));
            step();
        end
        dst_ready = '1;
        repeat (30) step();
        begin
            int miss;
            miss = 0;
            for (int s = 0; s < 8; s++)
                for (int d = 0; d < 9; d++)
                    if (issue_seq[s][d] != exp_seq[s][d]) miss++;
            chk(miss == 0, "R6 all delivered", miss, 0);
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule